// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Unit

A registered datapath that runs five signed multiply operations on 32-bit register operands. Each source can give either its upper or its lower 16 bits to the multiplier. The two forms that use a full word and a halfword multiply a whole 32-bit source by a halfword, then keep the upper 32 bits of the 48-bit product. Three of the operations add the product to an accumulator. Two of them use a 32-bit accumulator, and one, the long form, uses a 64-bit accumulator.

Operands, opcode and halfword selects are presented together with `valid_i`. The result appears on the next clock with `valid_o`. A sticky overflow flag records any signed overflow of the 32-bit accumulate. Results are never saturated. The flag stays set until it is cleared or reset.

Top module: `hmac_unit`

## Requirements
- R1: A select of 0 takes bits [15:0] of its source and a select of 1 takes bits [31:16]; the half is sign-extended. Opcode 0 (halfword multiply) returns the signed 16x16 product of the selected halves of `src_a_i` and `src_b_i`.
- R2: Opcode 1 (halfword multiply-accumulate) returns the 16x16 product plus `acc_i[31:0]`, wrapped modulo 2^32; `acc_i[63:32]` is ignored.
- R3: Opcode 2 (long multiply-accumulate) returns the sign-extended 16x16 product plus the full 64-bit `acc_i`, wrapped modulo 2^64.
- R4: Opcode 3 (word-by-half multiply) multiplies all 32 bits of `src_a_i` by the selected half of `src_b_i` and returns bits [47:16] of the 48-bit signed product; `sel_a_i` is ignored.
- R5: Opcode 4 (word-by-half multiply-accumulate) returns the R4 value plus `acc_i[31:0]`, wrapped modulo 2^32.
- R6: For every opcode other than 2, `result_o[63:32]` is zero.
- R7: `valid_o` equals `valid_i` delayed by exactly one clock, and the result for an accepted operation is on `result_o` in that same cycle.
- R8: While `valid_i` is low, `result_o` holds its last value.
- R9: A signed overflow of the 32-bit add in opcode 1 or 4 sets `ovf_o` one clock later; opcode 2 and the non-accumulating opcodes never set it.
- R10: `ovf_o` stays set until a cycle with `ovf_clr_i` high; if a new overflow arrives in the same cycle as the clear, the flag stays set.
- R11: While `rst_ni` is low, `result_o`, `valid_o` and `ovf_o` are all zero.
- R12: Opcodes 5 to 7 return zero and do not set `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode |
| sel_a_i | input | 1 | Half select for source A (1 = upper) |
| sel_b_i | input | 1 | Half select for source B (1 = upper) |
| src_a_i | input | 32 | Source A |
| src_b_i | input | 32 | Source B |
| acc_i | input | 64 | Accumulator (low 32 bits for the 32-bit forms) |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Registered result |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check the timing rules on every cycle:
- the one-clock valid delay;
- holding the result while idle;
- a zero upper word on 32-bit results;
- the flag rising only after an accumulating 32-bit opcode;
- the flag persisting and being cleared correctly.

The arithmetic itself can only be shown by the bench's scenarios. These cover:
- halfword selection and sign extension;
- the 48-bit product slice;
- wrapping of both accumulators;
- overflow in both directions;
- a clear in the same cycle as an overflow;
- unused opcodes.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    OP_MUL_HH  = 3'd0,
    OP_MAC_HH  = 3'd1,
    OP_MACL_HH = 3'd2,
    OP_MUL_WH  = 3'd3,
    OP_MAC_WH  = 3'd4
  } hmac_op_e;

  // signed add overflow from operand and sum sign bits
  function automatic logic add_ovf(input logic sgn_a, input logic sgn_b, input logic sgn_s);
    return (sgn_a == sgn_b) && (sgn_s != sgn_a);
  endfunction
endpackage

// File: rtl/hmac_halfsel.sv
module hmac_halfsel #(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2
) (
  input  logic [DW-1:0] word_i,
  input  logic          sel_i,
  output logic [HW-1:0] half_o
);
  assign half_o = sel_i ? word_i[DW-1:HW] : word_i[HW-1:0];
endmodule

// File: rtl/hmac_mul.sv
module hmac_mul #(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2,
  localparam int unsigned PW = DW + HW
) (
  input  logic [HW-1:0] a_half_i,
  input  logic [HW-1:0] b_half_i,
  input  logic [DW-1:0] a_word_i,
  output logic [DW-1:0] prod_hh_o,
  output logic [DW-1:0] prod_wh_o
);
  logic [DW-1:0] a_hx, b_hx;
  logic [PW-1:0] a_wx, b_wx, prod_w;
  logic          unused_low;

  assign a_hx = {{HW{a_half_i[HW-1]}}, a_half_i};
  assign b_hx = {{HW{b_half_i[HW-1]}}, b_half_i};
  assign prod_hh_o = $signed(a_hx) * $signed(b_hx);

  assign a_wx = {{HW{a_word_i[DW-1]}}, a_word_i};
  assign b_wx = {{DW{b_half_i[HW-1]}}, b_half_i};
  assign prod_w = $signed(a_wx) * $signed(b_wx);
  assign prod_wh_o = prod_w[PW-1:HW];
  assign unused_low = ^prod_w[HW-1:0];
endmodule

// File: rtl/hmac_acc.sv
module hmac_acc
  import hmac_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned AW = 2 * DW
) (
  input  hmac_op_e      op_i,
  input  logic [DW-1:0] prod_hh_i,
  input  logic [DW-1:0] prod_wh_i,
  input  logic [AW-1:0] acc_i,
  output logic [AW-1:0] res_o,
  output logic          ovf_o
);
  logic [DW-1:0] addend, sum_s;
  logic [AW-1:0] sum_l;

  assign addend = (op_i == OP_MAC_WH) ? prod_wh_i : prod_hh_i;
  assign sum_s  = addend + acc_i[DW-1:0];
  assign sum_l  = {{DW{prod_hh_i[DW-1]}}, prod_hh_i} + acc_i;

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    unique case (op_i)
      OP_MUL_HH:  res_o = {{DW{1'b0}}, prod_hh_i};
      OP_MUL_WH:  res_o = {{DW{1'b0}}, prod_wh_i};
      OP_MACL_HH: res_o = sum_l;
      OP_MAC_HH, OP_MAC_WH: begin
        res_o = {{DW{1'b0}}, sum_s};
        ovf_o = add_ovf(addend[DW-1], acc_i[DW-1], sum_s[DW-1]);
      end
      default: begin
        res_o = '0;
        ovf_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  localparam int unsigned HW = DW / 2,
  localparam int unsigned AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic          sel_a_i,
  input  logic          sel_b_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  input  logic [AW-1:0] acc_i,
  input  logic          ovf_clr_i,
  output logic          valid_o,
  output logic [AW-1:0] result_o,
  output logic          ovf_o
);
  logic [1:0][DW-1:0] src_arr;
  logic [1:0]         sel_arr;
  logic [1:0][HW-1:0] half_arr;
  logic [DW-1:0]      prod_hh, prod_wh;
  logic [AW-1:0]      res_c;
  logic               ovf_c;
  logic               valid_q, ovf_q;
  logic [AW-1:0]      res_q;

  assign src_arr = {src_b_i, src_a_i};
  assign sel_arr = {sel_b_i, sel_a_i};

  for (genvar g = 0; g < 2; g++) begin : g_sel
    hmac_halfsel #(.DW(DW)) u_sel (
      .word_i(src_arr[g]),
      .sel_i (sel_arr[g]),
      .half_o(half_arr[g])
    );
  end

  hmac_mul #(.DW(DW)) u_mul (
    .a_half_i (half_arr[0]),
    .b_half_i (half_arr[1]),
    .a_word_i (src_a_i),
    .prod_hh_o(prod_hh),
    .prod_wh_o(prod_wh)
  );

  hmac_acc #(.DW(DW)) u_acc (
    .op_i     (hmac_op_e'(op_i)),
    .prod_hh_i(prod_hh),
    .prod_wh_i(prod_wh),
    .acc_i    (acc_i),
    .res_o    (res_c),
    .ovf_o    (ovf_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_c;
      // a fresh overflow beats a clear in the same cycle
      if (valid_i && ovf_c) ovf_q <= 1'b1;
      else if (ovf_clr_i)   ovf_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/hmac_unit_chk.sv
module hmac_unit_chk #(
  parameter int unsigned DW = 32,
  localparam int unsigned AW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic          ovf_clr_i,
  input logic          valid_o,
  input logic [AW-1:0] result_o,
  input logic          ovf_o
);
  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_VALID_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd2) |=> (result_o[AW-1:DW] == '0)); // R6
  AST_OVF_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($past(valid_i) && ($past(op_i) == 3'd1 || $past(op_i) == 3'd4))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R10
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !(valid_i && (op_i == 3'd1 || op_i == 3'd4))) |=> !ovf_o); // R10
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !ovf_o && result_o == '0)); // R11
endmodule

bind hmac_unit hmac_unit_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .ovf_clr_i(ovf_clr_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .ovf_o    (ovf_o)
);

// File: tb/hmac_unit_test.sv
module hmac_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic        sa;
    logic        sb;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] acc;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    // R1 low halves, negative operand
    '{3'd0, 1'b0, 1'b0, 32'h0000_0003, 32'h0000_FFFE, 64'h0, 64'h0000_0000_FFFF_FFFA},
    // R1 upper half of A
    '{3'd0, 1'b1, 1'b0, 32'h0005_0000, 32'h0000_0007, 64'h0, 64'h23},
    // R1 most negative squared
    '{3'd0, 1'b1, 1'b1, 32'h8000_1234, 32'h8000_0000, 64'h0, 64'h4000_0000},
    // R2 simple accumulate
    '{3'd1, 1'b0, 1'b0, 32'h2, 32'h3, 64'h64, 64'h6A},
    // R2 upper accumulator ignored, no signed overflow
    '{3'd1, 1'b0, 1'b0, 32'h0000_FFFF, 32'h1, 64'hDEAD_0000_0000_0000, 64'h0000_0000_FFFF_FFFF},
    // R3 long accumulate with negative product
    '{3'd2, 1'b0, 1'b0, 32'h0000_FFFF, 32'h1, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF},
    // R3 wraps modulo 2^64
    '{3'd2, 1'b0, 1'b0, 32'h1, 32'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    // R4 low half of B, sel_a ignored
    '{3'd3, 1'b1, 1'b0, 32'h0001_0000, 32'h0000_0003, 64'h0, 64'h3},
    // R4 negative word, upper half of B
    '{3'd3, 1'b0, 1'b1, 32'hFFFF_0000, 32'h0002_0000, 64'h0, 64'h0000_0000_FFFF_FFFE},
    // R5
    '{3'd4, 1'b0, 1'b0, 32'h0002_0000, 32'h5, 64'h10, 64'h1A},
    // R12 unused opcode
    '{3'd5, 1'b0, 1'b0, 32'h0000_7FFF, 32'h7FFF, 64'h1234, 64'h0},
    // R3 sign-extended product into high accumulator
    '{3'd2, 1'b1, 1'b0, 32'hFFFE_0000, 32'h3, 64'h0000_0002_0000_0000, 64'h0000_0001_FFFF_FFFA}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        sel_a_i = 1'b0, sel_b_i = 1'b0;
  logic [31:0] src_a_i = '0, src_b_i = '0;
  logic [63:0] acc_i = '0;
  logic        ovf_clr_i = 1'b0;
  logic        valid_o, ovf_o;
  logic [63:0] result_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  hmac_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .acc_i(acc_i), .ovf_clr_i(ovf_clr_i), .valid_o(valid_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, capture on the rising edge, return at the next falling edge
  task automatic issue(input logic [2:0] op, input logic sa, input logic sb,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] acc, input logic clr);
    valid_i = 1'b1; op_i = op; sel_a_i = sa; sel_b_i = sb;
    src_a_i = a; src_b_i = b; acc_i = acc; ovf_clr_i = clr;
    @(posedge clk_i); @(negedge clk_i);
    valid_i = 1'b0; ovf_clr_i = 1'b0;
  endtask

  task automatic clear_flag();
    ovf_clr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    ovf_clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk_i);
    check("R11 result", result_o, 64'h0);
    check("R11 valid", {63'h0, valid_o}, 64'h0);
    check("R11 ovf", {63'h0, ovf_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].op, VECS[i].sa, VECS[i].sb, VECS[i].a, VECS[i].b, VECS[i].acc, 1'b0);
      check($sformatf("R7 vec%0d valid", i), {63'h0, valid_o}, 64'h1);
      check($sformatf("vec%0d result (R1-R5,R12)", i), result_o, VECS[i].exp);
      check($sformatf("R9 vec%0d no flag", i), {63'h0, ovf_o}, 64'h0);
    end

    // R7 strobe drops one clock after valid_i drops; R8 hold while idle
    held = result_o;
    op_i = 3'd0; src_a_i = 32'h7; src_b_i = 32'h9; acc_i = 64'h55;
    @(posedge clk_i); @(negedge clk_i);
    check("R7 valid low", {63'h0, valid_o}, 64'h0);
    check("R8 hold", result_o, held);

    // R9 positive overflow, opcode 1
    issue(3'd1, 1'b0, 1'b0, 32'h1, 32'h1, 64'h7FFF_FFFF, 1'b0);
    check("R2 wrapped sum", result_o, 64'h8000_0000);
    check("R9 flag set mac_hh", {63'h0, ovf_o}, 64'h1);
    // R10 stays set through an ordinary operation
    issue(3'd0, 1'b0, 1'b0, 32'h2, 32'h2, 64'h0, 1'b0);
    check("R10 sticky", {63'h0, ovf_o}, 64'h1);
    clear_flag();
    check("R10 cleared", {63'h0, ovf_o}, 64'h0);

    // R9 negative overflow, opcode 1
    issue(3'd1, 1'b0, 1'b0, 32'h0000_FFFF, 32'h1, 64'h8000_0000, 1'b0);
    check("R2 negative wrap", result_o, 64'h7FFF_FFFF);
    check("R9 flag negative", {63'h0, ovf_o}, 64'h1);
    clear_flag();

    // R9 opcode 4 overflow
    issue(3'd4, 1'b0, 1'b0, 32'h0001_0000, 32'h1, 64'h7FFF_FFFF, 1'b0);
    check("R5 wrapped sum", result_o, 64'h8000_0000);
    check("R9 flag mac_wh", {63'h0, ovf_o}, 64'h1);

    // R10 overflow in same cycle as clear keeps the flag
    issue(3'd1, 1'b0, 1'b0, 32'h1, 32'h1, 64'h7FFF_FFFF, 1'b1);
    check("R10 set beats clear", {63'h0, ovf_o}, 64'h1);
    clear_flag();
    check("R10 cleared again", {63'h0, ovf_o}, 64'h0);

    // R9 long form crosses signed 64-bit range without flag
    issue(3'd2, 1'b0, 1'b0, 32'h1, 32'h1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
    check("R3 long wrap", result_o, 64'h8000_0000_0000_0000);
    check("R9 long no flag", {63'h0, ovf_o}, 64'h0);

    // R12 unused opcode with overflow-prone operands
    issue(3'd7, 1'b0, 1'b0, 32'h1, 32'h1, 64'h7FFF_FFFF, 1'b0);
    check("R12 result zero", result_o, 64'h0);
    check("R12 no flag", {63'h0, ovf_o}, 64'h0);

    // R11 reset mid-run
    issue(3'd1, 1'b0, 1'b0, 32'h1, 32'h1, 64'h7FFF_FFFF, 1'b0);
    rst_ni = 1'b0;
    #1;
    check("R11 async result", result_o, 64'h0);
    check("R11 async ovf", {63'h0, ovf_o}, 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule